// File: doc/BRIEF.md
# Serial Command and Data Word Loader

This block sits between a boundary-scan user data register and a flash programmer. The host shifts a single serial stream through it on the slow test clock. The block packs the stream into 32-bit words and spends each word according to a fixed sequence:

1. The first three words become the programmer's load address, page count and subsector count, each with its own valid level.
2. The block then requests an erase and waits for the programmer's erasing flag to rise and fall.
3. Each word after that goes to the programmer FIFO as a single-cycle write on the test clock.

Throughout, the current erasing status is returned on the serial output while shifting, so the host can poll it. The test clock is taken to be far slower than the programmer clock, so the erasing flag is used without synchronizers. After the last data word of the programmed length, the block clears its valids and waits for a new address word. A capture pulse realigns word packing to a fresh boundary.

Top module: `scan_cmd_loader`

## Requirements
- R1: After reset the following are all low: the three valid outputs, `erase_req`, `fifo_wr` and `tdo`.
- R2: While `shift_en` is high, `tdi` is sampled on each rising edge of `tck`. The first sampled bit becomes bit 31 of the word (most significant first), and every 32 sampled bits form one word.
- R3: In the address-load phase the first word loads `start_addr` and sets `start_addr_vld`. The second word loads its low 17 bits into `page_cnt` and sets `page_cnt_vld`. The third word loads its low 13 bits into `sect_cnt` and sets `sect_cnt_vld`.
- R4: Once the third word is loaded, `erase_req` goes high. It stays high until `erasing_in` is seen high, then drops.
- R5: A word completed while the erase is pending or `erasing_in` is high is discarded. It produces no FIFO write and changes no register.
- R6: After `erasing_in` falls, each completed word produces exactly one cycle of `fifo_wr`, with `fifo_data` equal to that word.
- R7: After `page_cnt` × 64 data words, all valids clear and the next word is taken as a new address. A page count of 0 returns to the address phase as soon as the erase ends.
- R8: While `shift_en` is high, `tdo` shows `erasing_in` as sampled at the previous rising edge. While `shift_en` is low, `tdo` is low.
- R9: A high `capture` clears the bit counter and drops any partial word, so the next bit starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture | input | 1 | Realign word packing to a fresh boundary |
| shift_en | input | 1 | Serial shift qualifier |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial status out (erasing flag) |
| erasing_in | input | 1 | Erase-in-progress flag from the programmer |
| start_addr | output | 32 | Flash load address |
| start_addr_vld | output | 1 | Load address valid |
| page_cnt | output | 17 | Page count |
| page_cnt_vld | output | 1 | Page count valid |
| sect_cnt | output | 13 | Subsector erase count |
| sect_cnt_vld | output | 1 | Subsector count valid |
| erase_req | output | 1 | Erase request |
| fifo_data | output | 32 | Data word to the programmer FIFO |
| fifo_wr | output | 1 | FIFO write enable, one cycle per word |

## Verification
A bit counter that is off by one shows up as a rotated address on the very first word. A wrong sequencer state shows up as a word landing in the wrong register, or as a premature `fifo_wr` during the erase. Both appear within two clocks of the offending word's last bit. A data-word count error shows up only at the end of a page run: either the valids clear early and later words turn into addresses, or they never clear. The bench therefore checks register contents after every command word, and checks the valids immediately after the final data word of runs of 64, 128 and 0 words.

// File: rtl/scan_cmd_loader_pkg.sv
package scan_cmd_loader_pkg;
   typedef enum logic [2:0] {
      ST_ADDR  = 3'd0,
      ST_PAGE  = 3'd1,
      ST_SECT  = 3'd2,
      ST_ERASE = 3'd3,
      ST_BUSY  = 3'd4,
      ST_DATA  = 3'd5
   } ld_state_t;
endpackage

// File: rtl/scl_deser.sv
module scl_deser #(
   parameter int WORD_W    = 32,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              shift_en,
   input  logic              din,
   output logic [WORD_W-1:0] word,
   output logic              word_stb
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] sr, sr_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sr_next = {sr[WORD_W-2:0], din};
      end else begin : g_lsb
         assign sr_next = {din, sr[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         sr       <= '0;
         word     <= '0;
         word_stb <= 1'b0;
      end else begin
         word_stb <= 1'b0;
         if (capture) begin
            bit_cnt <= '0;
         end else if (shift_en) begin
            sr <= sr_next;
            if (bit_cnt == LAST) begin
               bit_cnt  <= '0;
               word     <= sr_next;
               word_stb <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (bit_cnt == '0)); // R9
   AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb); // R2
endmodule

// File: rtl/scl_status.sv
module scl_status (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic busy_in,
   output logic sout
);
   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy_in;
   end

   assign sout = shift_en & busy_q;

   AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && $past(shift_en)) |-> (sout == $past(busy_in))); // R8
endmodule

// File: rtl/scl_seq.sv
module scl_seq
   import scan_cmd_loader_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int PAGE_W    = 17,
   parameter int SECT_W    = 13,
   parameter int WORDS_PG  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   input  logic              word_stb,
   input  logic              erasing_in,
   output logic [WORD_W-1:0] start_addr,
   output logic              start_addr_vld,
   output logic [PAGE_W-1:0] page_cnt,
   output logic              page_cnt_vld,
   output logic [SECT_W-1:0] sect_cnt,
   output logic              sect_cnt_vld,
   output logic              erase_req,
   output logic [WORD_W-1:0] fifo_data,
   output logic              fifo_wr
);
   localparam int REM_W = PAGE_W + $clog2(WORDS_PG) + 1;

   ld_state_t        state;
   logic [REM_W-1:0] remain;
   logic [REM_W-1:0] total_words;

   assign total_words = REM_W'(page_cnt) * REM_W'(WORDS_PG);
   assign erase_req   = (state == ST_ERASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= ST_ADDR;
         remain         <= '0;
         start_addr     <= '0;
         start_addr_vld <= 1'b0;
         page_cnt       <= '0;
         page_cnt_vld   <= 1'b0;
         sect_cnt       <= '0;
         sect_cnt_vld   <= 1'b0;
         fifo_data      <= '0;
         fifo_wr        <= 1'b0;
      end else begin
         fifo_wr <= 1'b0;
         unique case (state)
            ST_ADDR: if (word_stb) begin
               start_addr     <= word;
               start_addr_vld <= 1'b1;
               state          <= ST_PAGE;
            end
            ST_PAGE: if (word_stb) begin
               page_cnt     <= word[PAGE_W-1:0];
               page_cnt_vld <= 1'b1;
               state        <= ST_SECT;
            end
            ST_SECT: if (word_stb) begin
               sect_cnt     <= word[SECT_W-1:0];
               sect_cnt_vld <= 1'b1;
               state        <= ST_ERASE;
            end
            ST_ERASE: if (erasing_in) state <= ST_BUSY;
            ST_BUSY: if (!erasing_in) begin
               if (page_cnt == '0) begin
                  start_addr_vld <= 1'b0;
                  page_cnt_vld   <= 1'b0;
                  sect_cnt_vld   <= 1'b0;
                  state          <= ST_ADDR;
               end else begin
                  remain <= total_words;
                  state  <= ST_DATA;
               end
            end
            ST_DATA: if (word_stb) begin
               fifo_wr   <= 1'b1;
               fifo_data <= word;
               if (remain == REM_W'(1)) begin
                  start_addr_vld <= 1'b0;
                  page_cnt_vld   <= 1'b0;
                  sect_cnt_vld   <= 1'b0;
                  state          <= ST_ADDR;
               end else begin
                  remain <= remain - 1'b1;
               end
            end
            default: state <= ST_ADDR;
         endcase
      end
   end

   AST_ERASE_HAS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (start_addr_vld && page_cnt_vld && sect_cnt_vld)); // R4
   AST_VLD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (sect_cnt_vld |-> page_cnt_vld) and (page_cnt_vld |-> start_addr_vld)); // R3
   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |=> !fifo_wr); // R6
   AST_NO_WR_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req || (state == ST_BUSY)) |=> !fifo_wr); // R5
endmodule

// File: rtl/scan_cmd_loader.sv
module scan_cmd_loader #(
   parameter int WORD_W     = 32,
   parameter int PAGE_W     = 17,
   parameter int SECT_W     = 13,
   parameter int PAGE_BYTES = 256,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              shift_en,
   input  logic              tdi,
   output logic              tdo,
   input  logic              erasing_in,
   output logic [WORD_W-1:0] start_addr,
   output logic              start_addr_vld,
   output logic [PAGE_W-1:0] page_cnt,
   output logic              page_cnt_vld,
   output logic [SECT_W-1:0] sect_cnt,
   output logic              sect_cnt_vld,
   output logic              erase_req,
   output logic [WORD_W-1:0] fifo_data,
   output logic              fifo_wr
);
   localparam int BYTES_W  = WORD_W / 8;
   localparam int WORDS_PG = PAGE_BYTES / BYTES_W;

   generate
      if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
         $error("WORD_W must be a whole number of bytes");
      end
      if (PAGE_BYTES % BYTES_W != 0) begin : g_bad_page
         $error("PAGE_BYTES must hold whole words");
      end
      if (PAGE_W > WORD_W || SECT_W > WORD_W) begin : g_bad_fields
         $error("count fields must fit in one word");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              word_stb;

   scl_deser #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_deser (
      .clk(tck), .rst_n(rst_n), .capture(capture), .shift_en(shift_en),
      .din(tdi), .word(word), .word_stb(word_stb));

   scl_seq #(.WORD_W(WORD_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W),
             .WORDS_PG(WORDS_PG)) u_seq (
      .clk(tck), .rst_n(rst_n), .word(word), .word_stb(word_stb),
      .erasing_in(erasing_in),
      .start_addr(start_addr), .start_addr_vld(start_addr_vld),
      .page_cnt(page_cnt), .page_cnt_vld(page_cnt_vld),
      .sect_cnt(sect_cnt), .sect_cnt_vld(sect_cnt_vld),
      .erase_req(erase_req), .fifo_data(fifo_data), .fifo_wr(fifo_wr));

   scl_status u_status (
      .clk(tck), .rst_n(rst_n), .shift_en(shift_en),
      .busy_in(erasing_in), .sout(tdo));
endmodule

// File: tb/sim_scan_cmd_loader.sv
`timescale 1ns/1ps
module sim_scan_cmd_loader;
   logic        tck = 1'b0, rst_n = 1'b0, capture = 1'b0, shift_en = 1'b0, tdi = 1'b0;
   logic        erasing_in = 1'b0;
   logic        tdo, start_addr_vld, page_cnt_vld, sect_cnt_vld, erase_req, fifo_wr;
   logic [31:0] start_addr, fifo_data;
   logic [16:0] page_cnt;
   logic [12:0] sect_cnt;
   int          total = 0, bad = 0;
   logic [31:0] exp_q[$];

   always #2 tck = ~tck;

   scan_cmd_loader u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pg_mask(input logic [31:0] w);
      return {15'd0, w[16:0]};
   endfunction

   always @(negedge tck) if (rst_n && fifo_wr) begin
      if (exp_q.size() == 0) chk(0, "R5/R6 unexpected fifo_wr", fifo_data, 32'h0);
      else begin
         logic [31:0] e;
         e = exp_q.pop_front();
         chk(fifo_data == e, "R6 fifo_data", fifo_data, e);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge tck);
   endtask

   task automatic send_word(input logic [31:0] w);
      for (int i = 31; i >= 0; i--) begin
         @(negedge tck);
         shift_en = 1'b1;
         tdi = w[i];
         #1;
         if (i == 31 || i == 0) chk(tdo == erasing_in, "R8 tdo during shift", 32'(tdo), 32'(erasing_in));
      end
      @(negedge tck);
      shift_en = 1'b0;
   endtask

   task automatic run_seq(input logic [31:0] addr, input int pages, input bit do_capture);
      logic [31:0] pw, sw;
      pw = {$urandom} & 32'hFFFE_0000 | 32'(pages);
      sw = $urandom;
      if (do_capture) begin
         for (int i = 0; i < 10; i++) begin
            @(negedge tck); shift_en = 1'b1; tdi = 1'b1;
         end
         @(negedge tck); shift_en = 1'b0; capture = 1'b1;
         @(negedge tck); capture = 1'b0;
      end
      send_word(addr); idle(2);
      chk(start_addr == addr && start_addr_vld, "R3 address load / R9 realign", start_addr, addr);
      chk(!page_cnt_vld, "R3 page not yet valid", 32'(page_cnt_vld), 32'h0);
      send_word(pw); idle(2);
      chk(32'(page_cnt) == pg_mask(pw) && page_cnt_vld, "R3 page load", 32'(page_cnt), pg_mask(pw));
      chk(!erase_req, "R4 no erase before third word", 32'(erase_req), 32'h0);
      send_word(sw); idle(2);
      chk(32'(sect_cnt) == {19'd0, sw[12:0]} && sect_cnt_vld, "R3 subsector load", 32'(sect_cnt), {19'd0, sw[12:0]});
      chk(erase_req, "R4 erase raised", 32'(erase_req), 32'h1);
      send_word($urandom); idle(2);
      chk(erase_req && start_addr == addr, "R5 word ignored while erase pending", start_addr, addr);
      erasing_in = 1'b1;
      idle(2);
      chk(!erase_req, "R4 erase dropped after erasing seen", 32'(erase_req), 32'h0);
      send_word($urandom); idle(2);
      chk(32'(page_cnt) == pg_mask(pw) && start_addr == addr, "R5 word ignored while erasing", start_addr, addr);
      erasing_in = 1'b0;
      idle(3);
      chk(tdo == 1'b0, "R8 tdo low when not shifting", 32'(tdo), 32'h0);
      if (pages == 0) begin
         chk(!start_addr_vld && !page_cnt_vld && !sect_cnt_vld, "R7 zero pages returns", 32'(start_addr_vld), 32'h0);
      end
      for (int k = 0; k < pages * 64; k++) begin
         logic [31:0] d;
         d = $urandom;
         exp_q.push_back(d);
         send_word(d);
         if (k == pages * 64 - 2) begin
            idle(2);
            chk(start_addr_vld && sect_cnt_vld, "R7 still valid before final word", 32'(start_addr_vld), 32'h1);
         end
      end
      idle(2);
      chk(exp_q.size() == 0, "R6 all words written", 32'(exp_q.size()), 32'h0);
      chk(!start_addr_vld && !page_cnt_vld && !sect_cnt_vld, "R7 valids cleared at end", 32'(start_addr_vld), 32'h0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      idle(3);
      chk(!start_addr_vld && !page_cnt_vld && !sect_cnt_vld && !erase_req && !fifo_wr && !tdo,
          "R1 reset state", {start_addr_vld, page_cnt_vld, sect_cnt_vld, erase_req, fifo_wr, tdo}, 32'h0);
      rst_n = 1'b1;
      idle(2);
      chk(!erase_req, "R1 idle after reset", 32'(erase_req), 32'h0);
      run_seq(32'h0026_F000, 1, 1'b1);
      run_seq($urandom, 2, 1'b0);
      run_seq(32'h0050_0000, 0, 1'b1);
      run_seq(32'h8000_0001, 1, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge tck);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule